// File: doc/BRIEF.md
# Enable-Qualified Multi-Bit Clock Crossing

This block carries a multi-bit control word from a source clock domain into an unrelated destination clock domain. Only a one-bit toggle flag is synchronized. The word is loaded into a source-domain register and held there. The source then flips a request toggle, which passes through a chain of destination flip-flops.

When the destination sees the synchronized toggle change, it waits a programmable number of its own cycles so that the held word has settled. It then copies the word into its output register and raises `dst_valid` for one cycle. An acknowledge toggle returns through its own synchronizer and clears `src_busy`. This tells the source that it may offer the next word.

The block suits slowly changing configuration or control values. The throughput is one word per full round trip, which is well below the destination clock rate.

Top module: `mbsync_xfer`

## Requirements
- R1: After both resets `dst_valid` is 0, `dst_word` is all zeros and `src_busy` is 0. No `dst_valid` pulse appears unless a load has been accepted.
- R2: A high `src_load` sampled on a `src_clk` edge while `src_busy` is 0 is accepted. `src_busy` reads 1 right after that edge.
- R3: A `src_load` sampled while `src_busy` is 1 is ignored. It produces no extra `dst_valid` pulse and does not change the delivered word.
- R4: Changes on `src_word` after the accepting edge do not alter the word that the destination delivers.
- R5: `dst_valid` first reads 1 after exactly SYNC_STAGES + SETTLE + 1 `dst_clk` rising edges, counted from the first such edge after the accepting `src_clk` edge.
- R6: `dst_valid` stays high for exactly one `dst_clk` cycle. `dst_word` changes only on the edge that raises `dst_valid`.
- R7: `dst_word` equals the `src_word` value sampled on the accepting edge.
- R8: `src_busy` returns to 0 on the ACK_STAGES-th `src_clk` edge after the `dst_clk` edge that raised `dst_valid`. A new load is accepted from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst | input | 1 | Source domain synchronous reset, active high |
| src_load | input | 1 | Request to send `src_word` |
| src_word | input | WIDTH | Word to be sent |
| src_busy | output | 1 | A transfer is in flight; further loads are ignored |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst | input | 1 | Destination domain synchronous reset, active high |
| dst_valid | output | 1 | One-cycle pulse when `dst_word` takes a new value |
| dst_word | output | WIDTH | Last word delivered |

## Verification
A delivered word is due SYNC_STAGES + SETTLE + 1 destination edges after the accepting source edge, which is five edges with the defaults. The release of `src_busy` is due ACK_STAGES source edges after that delivery. The bench keeps a free-running edge counter in each domain. It snapshots the counters at the accepting edge and at each destination edge, and compares the differences with these exact figures.

The two clocks are placed so that their rising edges never share a time step. This keeps the edge counts free of ordering races. Outputs are sampled on the falling edge of their own clock, or one time unit after a rising edge.

// File: rtl/mbsync_pkg.sv
package mbsync_pkg;

   // destination capture sequencer state
   typedef enum logic {
      CAP_IDLE  = 1'b0,
      CAP_COUNT = 1'b1
   } cap_state_e;

   // width of a counter that must reach n-1 (never below one bit)
   function automatic int cnt_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/mbsync_flop_chain.sv
module mbsync_flop_chain #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mbsync_flop_chain: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] stg;

   always_ff @(posedge clk) begin
      if (rst) stg <= '0;
      else     stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/mbsync_src.sv
module mbsync_src #(
   parameter int WIDTH      = 16,
   parameter int ACK_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [WIDTH-1:0] word,
   input  logic             ack_tgl_x,
   output logic             busy,
   output logic             req_tgl,
   output logic [WIDTH-1:0] hold
);

   logic ack_s;
   logic accept;

   mbsync_flop_chain #(.STAGES(ACK_STAGES)) u_ack_sync (
      .clk (clk),
      .rst (rst),
      .d   (ack_tgl_x),
      .q   (ack_s)
   );

   assign busy   = req_tgl ^ ack_s;
   assign accept = load & ~busy;

   // the word crosses only from this register, held while busy
   always_ff @(posedge clk) begin
      if (rst) begin
         hold    <= '0;
         req_tgl <= 1'b0;
      end else if (accept) begin
         hold    <= word;
         req_tgl <= ~req_tgl;
      end
   end

endmodule

// File: rtl/mbsync_dst.sv
module mbsync_dst
   import mbsync_pkg::*;
#(
   parameter int WIDTH       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int SETTLE      = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             req_tgl_x,
   input  logic [WIDTH-1:0] hold_x,
   output logic [WIDTH-1:0] word,
   output logic             valid,
   output logic             ack_tgl
);

   logic req_s;
   logic seen_q;
   logic det;
   logic fire;

   mbsync_flop_chain #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk (clk),
      .rst (rst),
      .d   (req_tgl_x),
      .q   (req_s)
   );

   always_ff @(posedge clk) begin
      if (rst) seen_q <= 1'b0;
      else     seen_q <= req_s;
   end

   assign det = req_s ^ seen_q;

   generate
      if (SETTLE < 0) begin : g_bad_settle
         $error("mbsync_dst: SETTLE must not be negative");
      end else if (SETTLE == 0) begin : g_direct
         assign fire = det;
      end else begin : g_delay
         localparam int CW = cnt_bits(SETTLE);
         localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);
         cap_state_e     st;
         logic [CW-1:0]  cnt;

         always_ff @(posedge clk) begin
            if (rst) begin
               st  <= CAP_IDLE;
               cnt <= '0;
            end else if (det) begin
               st  <= CAP_COUNT;
               cnt <= '0;
            end else if (st == CAP_COUNT) begin
               if (cnt == LAST) st  <= CAP_IDLE;
               else             cnt <= cnt + 1'b1;
            end
         end

         assign fire = (st == CAP_COUNT) && (cnt == LAST);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         word    <= '0;
         valid   <= 1'b0;
         ack_tgl <= 1'b0;
      end else begin
         valid <= fire;
         if (fire) begin
            word    <= hold_x;
            ack_tgl <= ~ack_tgl;
         end
      end
   end

endmodule

// File: rtl/mbsync_xfer.sv
module mbsync_xfer #(
   parameter int WIDTH       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int SETTLE      = 2,
   parameter int ACK_STAGES  = 2
) (
   input  logic             src_clk,
   input  logic             src_rst,
   input  logic             src_load,
   input  logic [WIDTH-1:0] src_word,
   output logic             src_busy,
   input  logic             dst_clk,
   input  logic             dst_rst,
   output logic             dst_valid,
   output logic [WIDTH-1:0] dst_word
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("mbsync_xfer: WIDTH must be at least 1");
      end
   endgenerate

   logic             req_tgl;
   logic             ack_tgl;
   logic [WIDTH-1:0] launch_word;

   mbsync_src #(.WIDTH(WIDTH), .ACK_STAGES(ACK_STAGES)) u_src (
      .clk       (src_clk),
      .rst       (src_rst),
      .load      (src_load),
      .word      (src_word),
      .ack_tgl_x (ack_tgl),
      .busy      (src_busy),
      .req_tgl   (req_tgl),
      .hold      (launch_word)
   );

   mbsync_dst #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES), .SETTLE(SETTLE)) u_dst (
      .clk       (dst_clk),
      .rst       (dst_rst),
      .req_tgl_x (req_tgl),
      .hold_x    (launch_word),
      .word      (dst_word),
      .valid     (dst_valid),
      .ack_tgl   (ack_tgl)
   );

endmodule

// File: rtl/mbsync_xfer_chk.sv
module mbsync_xfer_chk #(
   parameter int WIDTH = 16
) (
   input logic             src_clk,
   input logic             src_rst,
   input logic             src_load,
   input logic             src_busy,
   input logic [WIDTH-1:0] launch_word,
   input logic             dst_clk,
   input logic             dst_rst,
   input logic             dst_valid,
   input logic [WIDTH-1:0] dst_word
);

   // R2: an accepted load marks the source busy
   a_r2_busy_on_accept: assert property (@(posedge src_clk) disable iff (src_rst)
      (src_load && !src_busy) |=> src_busy);

   // R1: busy never rises without a load
   a_r1_no_spurious_busy: assert property (@(posedge src_clk) disable iff (src_rst)
      (!src_load && !src_busy) |=> !src_busy);

   // R3 / R4: the launched word is frozen while a transfer is in flight
   a_r3_hold_frozen: assert property (@(posedge src_clk) disable iff (src_rst)
      src_busy |=> $stable(launch_word));

   // R6: a single-cycle valid pulse
   a_r6_valid_single: assert property (@(posedge dst_clk) disable iff (dst_rst)
      dst_valid |=> !dst_valid);

   // R6: the output word moves only together with valid
   a_r6_word_stable: assert property (@(posedge dst_clk) disable iff (dst_rst)
      !dst_valid |-> $stable(dst_word));

endmodule

bind mbsync_xfer mbsync_xfer_chk #(.WIDTH(WIDTH)) u_chk (
   .src_clk     (src_clk),
   .src_rst     (src_rst),
   .src_load    (src_load),
   .src_busy    (src_busy),
   .launch_word (launch_word),
   .dst_clk     (dst_clk),
   .dst_rst     (dst_rst),
   .dst_valid   (dst_valid),
   .dst_word    (dst_word)
);

// File: tb/tb_mbsync_xfer.sv
module tb_mbsync_xfer;

   localparam int WIDTH       = 16;
   localparam int SYNC_STAGES = 2;
   localparam int SETTLE      = 2;
   localparam int ACK_STAGES  = 2;
   localparam int LAT         = SYNC_STAGES + SETTLE + 1;
   localparam int NVEC        = 6;

   // stimulus word, noise driven after accept, expected delivered word
   localparam logic [WIDTH-1:0] VEC_IN  [NVEC] = '{16'h0000, 16'hA5C3, 16'hFFFF, 16'h1234, 16'h8001, 16'h5A5A};
   localparam logic [WIDTH-1:0] VEC_NZ  [NVEC] = '{16'hDEAD, 16'h0000, 16'h0001, 16'hEDCB, 16'h7FFE, 16'hA5A5};
   localparam logic [WIDTH-1:0] VEC_EXP [NVEC] = '{16'h0000, 16'hA5C3, 16'hFFFF, 16'h1234, 16'h8001, 16'h5A5A};

   logic             src_clk = 1'b0;
   logic             dst_clk = 1'b0;
   logic             src_rst = 1'b1;
   logic             dst_rst = 1'b1;
   logic             src_load = 1'b0;
   logic [WIDTH-1:0] src_word = '0;
   logic             src_busy;
   logic             dst_valid;
   logic [WIDTH-1:0] dst_word;

   int n_chk = 0;
   int n_bad = 0;
   int dcyc  = 0;
   int scyc  = 0;
   int s_at_dedge = 0;
   int vcount = 0;
   bit done = 1'b0;

   // rising edges: dst on odd times, src on even times, never together
   always #5 dst_clk = ~dst_clk;
   initial begin
      #2 src_clk = 1'b1;
      forever #7 src_clk = ~src_clk;
   end

   always @(posedge dst_clk) begin
      dcyc++;
      s_at_dedge = scyc;
   end
   always @(posedge src_clk) scyc++;
   always @(negedge dst_clk) if (dst_valid) vcount++;

   mbsync_xfer #(
      .WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES), .SETTLE(SETTLE), .ACK_STAGES(ACK_STAGES)
   ) dut (
      .src_clk   (src_clk),
      .src_rst   (src_rst),
      .src_load  (src_load),
      .src_word  (src_word),
      .src_busy  (src_busy),
      .dst_clk   (dst_clk),
      .dst_rst   (dst_rst),
      .dst_valid (dst_valid),
      .dst_word  (dst_word)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   task automatic do_reset();
      src_rst = 1'b1;
      dst_rst = 1'b1;
      src_load = 1'b0;
      repeat (4) @(negedge src_clk);
      repeat (4) @(negedge dst_clk);
      @(negedge src_clk) src_rst = 1'b0;
      @(negedge dst_clk) dst_rst = 1'b0;
   endtask

   // one full transfer with timing checks
   task automatic xfer(input logic [WIDTH-1:0] w, input logic [WIDTH-1:0] nz, input logic [WIDTH-1:0] exp);
      int d0;
      int lat;
      int scap;
      int sedges;
      bit seen;
      @(negedge src_clk);
      src_word = w;
      src_load = 1'b1;
      @(posedge src_clk);
      d0 = dcyc;
      #1;
      src_load = 1'b0;
      src_word = nz;
      check(src_busy == 1'b1, "R2 busy after accept", src_busy, 1);
      seen = 1'b0;
      for (int i = 0; i < 40; i++) begin
         @(negedge dst_clk);
         if (dst_valid) begin
            seen = 1'b1;
            break;
         end
      end
      lat  = dcyc - d0;
      scap = s_at_dedge;
      check(seen, "R5 valid arrives", seen, 1);
      check(lat == LAT, "R5 latency in dst edges", lat, LAT);
      check(dst_word == exp, "R7 R4 delivered word", dst_word, exp);
      @(negedge dst_clk);
      check(dst_valid == 1'b0, "R6 valid one cycle", dst_valid, 0);
      check(dst_word == exp, "R6 word held", dst_word, exp);
      sedges = -1;
      for (int i = 0; i < 40; i++) begin
         @(negedge src_clk);
         if (!src_busy) begin
            sedges = scyc - scap;
            break;
         end
      end
      check(sedges == ACK_STAGES, "R8 busy release in src edges", sedges, ACK_STAGES);
   endtask

   initial begin
      int v0;
      do_reset();
      #1;
      // R1 reset state
      check(dst_valid == 1'b0, "R1 valid after reset", dst_valid, 0);
      check(dst_word == '0, "R1 word after reset", dst_word, 0);
      check(src_busy == 1'b0, "R1 busy after reset", src_busy, 0);
      repeat (20) @(negedge dst_clk);
      check(vcount == 0, "R1 no spurious transfer", vcount, 0);

      // table of vectors, back to back
      for (int k = 0; k < NVEC; k++) begin
         v0 = vcount;
         xfer(VEC_IN[k], VEC_NZ[k], VEC_EXP[k]);
         check(vcount == v0 + 1, "R6 one pulse per transfer", vcount, v0 + 1);
      end

      // R3: load while busy is ignored
      v0 = vcount;
      @(negedge src_clk);
      src_word = 16'h3C3C;
      src_load = 1'b1;
      @(negedge src_clk);
      src_load = 1'b0;
      src_word = 16'hC3C3;
      @(negedge src_clk);
      check(src_busy == 1'b1, "R3 busy during transfer", src_busy, 1);
      src_load = 1'b1;
      @(negedge src_clk);
      src_load = 1'b0;
      for (int i = 0; i < 40; i++) begin
         @(negedge src_clk);
         if (!src_busy) break;
      end
      repeat (30) @(negedge dst_clk);
      check(vcount == v0 + 1, "R3 ignored load adds no pulse", vcount, v0 + 1);
      check(dst_word == 16'h3C3C, "R3 ignored load leaves word", dst_word, 16'h3C3C);
      check(src_busy == 1'b0, "R3 no transfer started by ignored load", src_busy, 0);

      // R8: a new load is accepted once busy is low
      xfer(16'h0F0F, 16'hF0F0, 16'h0F0F);

      // R1 again after a mid-run reset
      do_reset();
      #1;
      check(dst_word == '0, "R1 word after second reset", dst_word, 0);
      check(src_busy == 1'b0, "R1 busy after second reset", src_busy, 0);
      v0 = vcount;
      repeat (20) @(negedge dst_clk);
      check(vcount == v0, "R1 quiet after second reset", vcount, v0);

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

endmodule